// File: doc/BRIEF.md
# Raster timing generator

This block generates the scan timing for a progressive display. Software writes a small register file over a write-only bus. It sets the line and frame lengths, the last active pixel and line, the sync windows and a prefetch position, and then sets the run bits. The block then steps a pixel counter and a line counter. From those counters it produces a display-enable window, horizontal and vertical sync, and a one-pixel early-fetch pulse that lets a pixel pipeline start reading before the next line begins.

Every timing register holds a final count, so a value of N means positions 0 through N. Writes to the timing registers are staged. They reach the counters only at a frame boundary, or at once while the generator is stopped. The sync and blanking controls act immediately. Each sync has its own polarity inversion and its own suppression bit, and a master bit turns both syncs off. A separate blank bit keeps display-enable low, which darkens the picture without stopping the timing.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset both counters read 0, and de_o, prefetch_o, hsync_o, vsync_o and sync_on_rgb_o are all low.
- R2: Word addresses are 1 line total, 2 last active pixel, 3 hsync start, 4 hsync end, 5 frame total, 6 last active line, 7 vsync start, 8 vsync end and 9 prefetch. Each holds a count minus one. While running, the pixel counter steps from 0 to the line-total value and wraps to 0. The line counter steps on each wrap and returns to 0 after the frame-total value.
- R3: de_o is high exactly when the pixel count is at or below the last-active-pixel value and the line count is at or below the last-active-line value, provided the generator is running, refresh is on and blank is off.
- R4: Before polarity, hsync is active for pixel counts above the hsync-start value and up to and including the hsync-end value. vsync follows the same rule on the line count and spans whole lines.
- R5: prefetch_o pulses for the single pixel whose count equals the prefetch value, on every line, while running with refresh on.
- R6: Control register (address 0): bit 0 runs the generator and bit 1 enables refresh. With bit 0 clear, both counters return to 0 one cycle later and both syncs sit at their inactive level.
- R7: Sync register (address 10): bit 3 inverts hsync and bit 4 inverts vsync, so the inactive level becomes high.
- R8: In the sync register, bit 1 forces both syncs inactive, bit 5 forces only hsync inactive and bit 6 forces only vsync inactive. The other sync keeps running.
- R9: Display register (address 11): bit 1 holds de_o low while the counters and syncs continue.
- R10: Sync register bit 0 appears directly on sync_on_rgb_o.
- R11: Timing values written while running take effect at the first pixel of the next frame, so the current frame ends with the old values.
- R12: With refresh (control bit 1) clear and the generator running, de_o and prefetch_o stay low while the counters and syncs run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | CNT_W | Write data |
| h_count_o | output | CNT_W | Pixel counter |
| v_count_o | output | CNT_W | Line counter |
| de_o | output | 1 | Display enable |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| prefetch_o | output | 1 | Early line-fetch pulse |
| sync_on_rgb_o | output | 1 | Sync-on-colour request |

## Verification
The main mode is a small frame of 16 pixels by 8 lines with every porch non-zero. Run for two whole frames, it separates off-by-one errors at each window edge and shows that the counters wrap correctly back to back. Each control variant then runs one more frame: both syncs inverted, each sync suppressed alone, power-down, blank and refresh off. Each of these tells a single control bit apart from its neighbours. A final run writes a second, smaller mode partway through a frame, which shows whether the new values reach the counters early or only at the frame boundary.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int ADDR_W     = 4;
  localparam int NUM_TIMING = 9;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam int                A_TBASE = 1;
  localparam logic [ADDR_W-1:0] A_SYNC = 4'd10;
  localparam logic [ADDR_W-1:0] A_DISP = 4'd11;

  // timing slot order follows word address minus A_TBASE
  localparam int T_HTOT  = 0;
  localparam int T_HDISP = 1;
  localparam int T_HSS   = 2;
  localparam int T_HSE   = 3;
  localparam int T_VTOT  = 4;
  localparam int T_VDISP = 5;
  localparam int T_VSS   = 6;
  localparam int T_VSE   = 7;
  localparam int T_PF    = 8;

  localparam int CTL_RUN     = 0;
  localparam int CTL_REFRESH = 1;
  localparam int SY_RGB      = 0;
  localparam int SY_ALL_OFF  = 1;
  localparam int SY_INV_H    = 3;
  localparam int SY_INV_V    = 4;
  localparam int SY_OFF_H    = 5;
  localparam int SY_OFF_V    = 6;
  localparam int DSP_BLANK   = 1;

  typedef struct packed {
    logic on_rgb;
    logic all_off;
    logic inv_h;
    logic inv_v;
    logic off_h;
    logic off_v;
  } sync_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [CNT_W-1:0]                 wr_data_i,
  input  logic                             reload_i,
  output logic [NUM_TIMING-1:0][CNT_W-1:0] timing_o,
  output logic                             run_o,
  output logic                             refresh_o,
  output sync_cfg_t                        sync_o,
  output logic                             blank_o
);

  generate
    for (genvar i = 0; i < NUM_TIMING; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(A_TBASE + i);
      logic [CNT_W-1:0] pend_q, act_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= '0;
          act_q  <= '0;
        end else begin
          if (wr_en_i && wr_addr_i == SLOT_ADDR) pend_q <= wr_data_i;
          // staged copy reaches the counters only at a frame edge or when stopped
          if (reload_i) act_q <= pend_q;
        end
      end

      assign timing_o[i] = act_q;
    end
  endgenerate

  logic      run_q, refresh_q, blank_q;
  sync_cfg_t sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      refresh_q <= 1'b0;
      blank_q   <= 1'b0;
      sync_q    <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) begin
        run_q     <= wr_data_i[CTL_RUN];
        refresh_q <= wr_data_i[CTL_REFRESH];
      end
      if (wr_addr_i == A_SYNC) begin
        sync_q.on_rgb  <= wr_data_i[SY_RGB];
        sync_q.all_off <= wr_data_i[SY_ALL_OFF];
        sync_q.inv_h   <= wr_data_i[SY_INV_H];
        sync_q.inv_v   <= wr_data_i[SY_INV_V];
        sync_q.off_h   <= wr_data_i[SY_OFF_H];
        sync_q.off_v   <= wr_data_i[SY_OFF_V];
      end
      if (wr_addr_i == A_DISP) blank_q <= wr_data_i[DSP_BLANK];
    end
  end

  assign run_o     = run_q;
  assign refresh_o = refresh_q;
  assign sync_o    = sync_q;
  assign blank_o   = blank_q;

endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] htot_i,
  input  logic [CNT_W-1:0] vtot_i,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o,
  output logic             frame_end_o
);

  logic [CNT_W-1:0] h_q, v_q;
  logic             line_end, last_line;

  assign line_end    = (h_q == htot_i);
  assign last_line   = (v_q == vtot_i);
  assign frame_end_o = run_i && line_end && last_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!run_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end) begin
      h_q <= '0;
      v_q <= last_line ? '0 : v_q + CNT_W'(1);
    end else begin
      h_q <= h_q + CNT_W'(1);
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

endmodule

// File: rtl/rtg_outputs.sv
module rtg_outputs
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0]                 h_i,
  input  logic [CNT_W-1:0]                 v_i,
  input  logic [NUM_TIMING-1:0][CNT_W-1:0] timing_i,
  input  logic                             run_i,
  input  logic                             refresh_i,
  input  sync_cfg_t                        sync_i,
  input  logic                             blank_i,
  output logic                             de_o,
  output logic                             hsync_o,
  output logic                             vsync_o,
  output logic                             prefetch_o,
  output logic                             sync_on_rgb_o
);

  logic h_win, v_win, h_act, v_act, fetch_ok;

  // start value is the last pixel before the pulse, end value the last pixel in it
  assign h_win = (h_i > timing_i[T_HSS]) && (h_i <= timing_i[T_HSE]);
  assign v_win = (v_i > timing_i[T_VSS]) && (v_i <= timing_i[T_VSE]);

  assign h_act = run_i && h_win && !sync_i.all_off && !sync_i.off_h;
  assign v_act = run_i && v_win && !sync_i.all_off && !sync_i.off_v;

  assign hsync_o = h_act ^ sync_i.inv_h;
  assign vsync_o = v_act ^ sync_i.inv_v;

  assign fetch_ok   = run_i && refresh_i;
  assign de_o       = fetch_ok && !blank_i &&
                      (h_i <= timing_i[T_HDISP]) && (v_i <= timing_i[T_VDISP]);
  assign prefetch_o = fetch_ok && (h_i == timing_i[T_PF]);

  assign sync_on_rgb_o = sync_i.on_rgb;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  h_count_o,
  output logic [CNT_W-1:0]  v_count_o,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              prefetch_o,
  output logic              sync_on_rgb_o
);

  logic [NUM_TIMING-1:0][CNT_W-1:0] timing;
  logic      ctl_run, ctl_refresh, ctl_blank, frame_end;
  sync_cfg_t sync_cfg;

  rtg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .reload_i  (!ctl_run || frame_end),
    .timing_o  (timing),
    .run_o     (ctl_run),
    .refresh_o (ctl_refresh),
    .sync_o    (sync_cfg),
    .blank_o   (ctl_blank)
  );

  rtg_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (ctl_run),
    .htot_i      (timing[T_HTOT]),
    .vtot_i      (timing[T_VTOT]),
    .h_o         (h_count_o),
    .v_o         (v_count_o),
    .frame_end_o (frame_end)
  );

  rtg_outputs #(.CNT_W(CNT_W)) u_out (
    .h_i           (h_count_o),
    .v_i           (v_count_o),
    .timing_i      (timing),
    .run_i         (ctl_run),
    .refresh_i     (ctl_refresh),
    .sync_i        (sync_cfg),
    .blank_i       (ctl_blank),
    .de_o          (de_o),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .prefetch_o    (prefetch_o),
    .sync_on_rgb_o (sync_on_rgb_o)
  );

endmodule

// File: rtl/rtg_chk.sv
module rtg_chk
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             refresh_i,
  input logic             blank_i,
  input sync_cfg_t        sync_i,
  input logic [CNT_W-1:0] h_i,
  input logic [CNT_W-1:0] v_i,
  input logic [CNT_W-1:0] htot_i,
  input logic [CNT_W-1:0] vtot_i,
  input logic             de_i,
  input logic             hsync_i,
  input logic             prefetch_i
);

  // R6
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (h_i == '0 && v_i == '0));

  // R2
  h_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && h_i != htot_i) |=> (h_i == $past(h_i) + CNT_W'(1)));

  // R11
  frame_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !(h_i == htot_i && v_i == vtot_i)) |=> ($stable(htot_i) && $stable(vtot_i)));

  // R9
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> !de_i);

  // R12
  refresh_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_i |-> (!de_i && !prefetch_i));

  // R8
  hsync_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i.off_h || sync_i.all_off) |-> (hsync_i == sync_i.inv_h));

endmodule

bind raster_timing_gen rtg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (ctl_run),
  .refresh_i  (ctl_refresh),
  .blank_i    (ctl_blank),
  .sync_i     (sync_cfg),
  .h_i        (h_count_o),
  .v_i        (v_count_o),
  .htot_i     (timing[T_HTOT]),
  .vtot_i     (timing[T_VTOT]),
  .de_i       (de_o),
  .hsync_i    (hsync_o),
  .prefetch_i (prefetch_o)
);

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] h_cnt, v_cnt;
  logic          de, hs, vs, pf, rgb;

  raster_timing_gen #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .h_count_o(h_cnt), .v_count_o(v_cnt), .de_o(de),
    .hsync_o(hs), .vsync_o(vs), .prefetch_o(pf), .sync_on_rgb_o(rgb)
  );

  always #2.5 clk = ~clk;

  typedef struct { int h; int v; bit de; bit hs; bit vs; bit pf; } exp_t;
  typedef struct { int w; int fp; int sl; int bp; int lh; int lfp; int lsl; int lbp; int pfc; } mode_t;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit f_refresh = 1, f_blank = 0, f_inv_h = 0, f_inv_v = 0;
  bit f_off_h = 0, f_off_v = 0, f_all_off = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int htotal(input mode_t m); return m.w + m.fp + m.sl + m.bp; endfunction
  function automatic int vtotal(input mode_t m); return m.lh + m.lfp + m.lsl + m.lbp; endfunction
  function automatic int pfpos(input mode_t m);
    int c = (m.pfc >= htotal(m)) ? htotal(m) - 1 : m.pfc;
    return htotal(m) - c - 1;
  endfunction

  // timing registers hold final counts (value minus one)
  task automatic program_mode(input mode_t m);
    wr(1, htotal(m) - 1);
    wr(2, m.w - 1);
    wr(3, m.w + m.fp - 1);
    wr(4, m.w + m.fp + m.sl - 1);
    wr(5, vtotal(m) - 1);
    wr(6, m.lh - 1);
    wr(7, m.lh + m.lfp - 1);
    wr(8, m.lh + m.lfp + m.lsl - 1);
    wr(9, pfpos(m));
  endtask

  task automatic push_frame(input mode_t m);
    for (int y = 0; y < vtotal(m); y++) begin
      for (int x = 0; x < htotal(m); x++) begin
        exp_t e;
        bit hw, vw;
        hw = (x >= m.w + m.fp) && (x < m.w + m.fp + m.sl);
        vw = (y >= m.lh + m.lfp) && (y < m.lh + m.lfp + m.lsl);
        e.h  = x;
        e.v  = y;
        e.de = f_refresh && !f_blank && (x < m.w) && (y < m.lh);
        e.hs = (hw && !f_off_h && !f_all_off) ^ f_inv_h;
        e.vs = (vw && !f_off_v && !f_all_off) ^ f_inv_v;
        e.pf = f_refresh && (x == pfpos(m));
        q.push_back(e);
      end
    end
  endtask

  // control write and expected frames are queued at the same negedge
  task automatic run_frames(input mode_t m, input int frames, input int ctrl);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = CW'(ctrl);
    for (int f = 0; f < frames; f++) push_frame(m);
    @(negedge clk);
    wr_en = 1'b0;
    wait (q.size() == 0);
  endtask

  task automatic stop_run();
    wr(0, 0);
    @(negedge clk);
    // R6: counters cleared, syncs at inactive level
    chk(h_cnt == 0 && v_cnt == 0, "R6", "counters zero when stopped", int'(h_cnt) + int'(v_cnt), 0);
    chk(hs == f_inv_h, "R6", "hsync idle level", hs, f_inv_h);
    chk(vs == f_inv_v, "R6", "vsync idle level", vs, f_inv_v);
  endtask

  always @(posedge clk) begin : mon
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(int'(h_cnt) == e.h, {"R2 ", cur_tag}, "pixel count", int'(h_cnt), e.h);
      chk(int'(v_cnt) == e.v, {"R2 ", cur_tag}, "line count", int'(v_cnt), e.v);
      chk(de == e.de, {"R3 ", cur_tag}, "display enable", de, e.de);
      chk(hs == e.hs, {"R4 ", cur_tag}, "hsync", hs, e.hs);
      chk(vs == e.vs, {"R4 ", cur_tag}, "vsync", vs, e.vs);
      chk(pf == e.pf, {"R5 ", cur_tag}, "prefetch", pf, e.pf);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    mode_t ma, mb;
    ma = '{w:8, fp:2, sl:3, bp:3, lh:4, lfp:1, lsl:2, lbp:1, pfc:4};
    mb = '{w:6, fp:1, sl:2, bp:1, lh:3, lfp:1, lsl:1, lbp:1, pfc:2};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(h_cnt == 0 && v_cnt == 0, "R1", "counters after reset", int'(h_cnt) + int'(v_cnt), 0);
    chk(!de && !pf, "R1", "de/prefetch after reset", int'(de) + int'(pf), 0);
    chk(!hs && !vs, "R1", "syncs after reset", int'(hs) + int'(vs), 0);
    chk(!rgb, "R1", "sync on rgb after reset", rgb, 0);

    // R6 programming while stopped leaves counters idle
    program_mode(ma);
    repeat (4) @(negedge clk);
    chk(h_cnt == 0 && v_cnt == 0, "R6", "idle while stopped", int'(h_cnt) + int'(v_cnt), 0);

    cur_tag = "main";
    run_frames(ma, 2, 3);
    stop_run();

    // R7 both syncs inverted
    wr(10, 32'h18); f_inv_h = 1; f_inv_v = 1;
    @(negedge clk);
    chk(hs && vs, "R7", "inverted idle levels high", int'(hs) + int'(vs), 2);
    cur_tag = "R7";
    run_frames(ma, 1, 3);
    stop_run();

    // R8 hsync suppressed alone
    wr(10, 32'h20); f_inv_h = 0; f_inv_v = 0; f_off_h = 1;
    cur_tag = "R8 hoff";
    run_frames(ma, 1, 3);
    stop_run();

    // R8 vsync suppressed alone
    wr(10, 32'h40); f_off_h = 0; f_off_v = 1;
    cur_tag = "R8 voff";
    run_frames(ma, 1, 3);
    stop_run();

    // R8 + R9 power-down: all sync off and blanked
    wr(10, 32'h02); wr(11, 32'h02); f_off_v = 0; f_all_off = 1; f_blank = 1;
    cur_tag = "R8 R9 powerdown";
    run_frames(ma, 1, 3);
    stop_run();

    // R9 blank only
    wr(10, 0); f_all_off = 0;
    cur_tag = "R9";
    run_frames(ma, 1, 3);
    stop_run();

    // R12 refresh off, running
    wr(11, 0); f_blank = 0; f_refresh = 0;
    cur_tag = "R12";
    run_frames(ma, 1, 1);
    stop_run();
    f_refresh = 1;

    // R10 sync-on-colour bit
    wr(10, 1);
    chk(rgb == 1'b1, "R10", "sync on rgb set", rgb, 1);
    wr(10, 0);
    chk(rgb == 1'b0, "R10", "sync on rgb clear", rgb, 0);

    // R11 new timing written mid-frame applies at next frame
    cur_tag = "R11";
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = CW'(3);
    push_frame(ma);
    push_frame(mb);
    @(negedge clk);
    wr_en = 1'b0;
    program_mode(mb);
    wait (q.size() == 0);
    stop_run();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule